// File: doc/BRIEF.md
# Repetitive Trace Pattern Detector

This block sits beside the fetch path of a processor that can turn a repeating run of traces into a single vectorized loop body. It sees one trace identifier per cycle, when one is offered. It looks for the point at which the most recent identifiers form a loop that has come round often enough to be worth vectorizing. Identifiers enter a short history window. On every accepted identifier, the newest k identifiers are compared against the k identifiers just before them, for every k from 1 to `KMAX`, all in parallel.

The longest matching group wins. A repetition counter tracks how long that same group length has kept matching. A vectorize event is raised only once the group has been seen `REPS` times in a row. The event is a one-cycle pulse that carries the group length and the identifiers of the group. A flush input discards the history and the count, for example after a redirect. The block does not merge traces, consult any cache or dispatch work.

Top module: `trace_repeat_detector`

## Requirements
- R1: During and after reset, `vec_pulse` is 0, `vec_len` is 0 and `vec_ids` is all zero until a qualifying repetition has been seen.
- R2: A group length k can match only when all 2k compared identifiers, counting the one arriving this cycle, were accepted since the last reset or flush. An unfilled history entry never produces a match.
- R3: On each accepted identifier, group lengths 1 to `KMAX` are tested in parallel. A group length k matches when window[i] equals window[i+k] for every i below k, where window[0] is the arriving identifier and window[j] is the one accepted j identifiers earlier. The largest matching k is selected.
- R4: The repetition count rises by one on each accepted identifier for which the selected length equals the length selected on the previous accepted identifier. A pulse fires on the accepted identifier that brings the count to (REPS-2)*k+1. At that point the newest REPS*k identifiers form REPS copies of one group.
- R5: The repetition count restarts at 1 when the selected length differs from the previous one. It restarts at 0 when no length matches.
- R6: After a pulse, the repetition count returns to 0, so a continuing loop fires again only after a further (REPS-2)*k+1 accepted identifiers with the same length.
- R7: The pulse lasts exactly one cycle, in the cycle after the edge that accepted the completing identifier. With it, `vec_len` gives k and `vec_ids` gives the k newest identifiers, slot j at bits [j*ID_W +: ID_W] with slot 0 the newest. Slots at or above k are zero, and all of these outputs are zero when there is no pulse.
- R8: Asserting `flush` empties the history and clears the count. Flush takes priority over `in_valid` in the same cycle, so that identifier is dropped.
- R9: A cycle with `in_valid` low changes neither the history nor the count, and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clear history and repetition count |
| in_valid | input | 1 | An identifier is offered this cycle |
| in_id | input | ID_W | Trace identifier |
| vec_pulse | output | 1 | One-cycle vectorize event |
| vec_len | output | $clog2(KMAX+1) | Length of the repeating group |
| vec_ids | output | KMAX*ID_W | Identifiers of the group, slot 0 newest |

## Verification
On every cycle, the assertions check the following:
- the pulse never lasts two cycles;
- a pulse always carries a length between 1 and `KMAX`, and the outputs are quiet without one;
- the history valid bits stay a contiguous run from the newest entry;
- flush empties the history and the count, and idle cycles leave the count and the locked length unchanged.

Only the bench's scenarios can show two things. One is that the pulse lands on exactly the right identifier for loops of each length, including a period-4 loop whose inner run of equal identifiers fires first as a length-1 group. The other is that restarts on a length change, re-firing on a long loop, and identifiers dropped during flush all agree with a behavioural model.

// File: rtl/rtd_pkg.sv
// Package: shared defaults and the firing-count rule for the repeat detector.
// Assumes REPS >= 2 and k >= 1 wherever fire_count is used.
package rtd_pkg;
    localparam int DEF_ID_W = 8;
    localparam int DEF_KMAX = 4;
    localparam int DEF_REPS = 3;

    // Number of consecutive same-length matches needed for REPS copies of a k-group.
    function automatic int fire_count(input int k, input int reps);
        return (reps - 2) * k + 1;
    endfunction
endpackage

// File: rtl/rtd_history.sv
// History window: holds the last 2*KMAX-1 accepted identifiers with valid bits.
// Presents the candidate window (arriving id plus stored entries) to the comparators.
// Assumes flush has priority over push; entry 0 is the newest.
module rtd_history #(
    parameter int ID_W = 8,
    parameter int KMAX = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      push,
    input  logic [ID_W-1:0]           id_in,
    output logic [2*KMAX-1:0][ID_W-1:0] cand,
    output logic [2*KMAX-1:0]         cand_vld
);
    localparam int STORE = 2 * KMAX - 1;

    logic [STORE-1:0][ID_W-1:0] hist_q;
    logic [STORE-1:0]           vld_q;

    // Shift the accepted identifier in at the newest end; clear on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hist_q <= '0;
            vld_q  <= '0;
        end else if (push) begin
            if (STORE > 1) begin
                hist_q <= {hist_q[STORE-2:0], id_in};
                vld_q  <= {vld_q[STORE-2:0], 1'b1};
            end else begin
                hist_q[0] <= id_in;
                vld_q[0]  <= 1'b1;
            end
        end
    end

    // Candidate window seen by the comparators: arriving id at slot 0.
    always_comb begin
        cand[0]     = id_in;
        cand_vld[0] = 1'b1;
        for (int j = 1; j < 2 * KMAX; j++) begin
            cand[j]     = hist_q[j-1];
            cand_vld[j] = vld_q[j-1];
        end
    end

    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));

    assert_valid_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((vld_q & (vld_q + 1'b1)) == '0));
endmodule

// File: rtl/rtd_compare.sv
// Parallel group comparators for k = 1..KMAX and a largest-match selector.
// Assumes cand[0] is the newest identifier; a length matches only if all 2k entries are valid.
module rtd_compare #(
    parameter int ID_W  = 8,
    parameter int KMAX  = 4,
    parameter int LEN_W = 3
) (
    input  logic [2*KMAX-1:0][ID_W-1:0] cand,
    input  logic [2*KMAX-1:0]           cand_vld,
    output logic [LEN_W-1:0]            best
);
    logic [KMAX-1:0] match;

    for (genvar g = 0; g < KMAX; g++) begin : g_len
        localparam int K = g + 1;
        logic m;
        // Compare newest K identifiers against the K just older, qualified by valid bits.
        always_comb begin
            m = 1'b1;
            for (int i = 0; i < 2 * K; i++) begin
                if (!cand_vld[i]) m = 1'b0;
            end
            for (int i = 0; i < K; i++) begin
                if (cand[i] != cand[i+K]) m = 1'b0;
            end
        end
        assign match[g] = m;
    end

    // Priority select: the largest matching length wins.
    always_comb begin
        best = '0;
        for (int k = 1; k <= KMAX; k++) begin
            if (match[k-1]) best = LEN_W'(k);
        end
    end
endmodule

// File: rtl/rtd_counter.sv
// Repetition counter and event register: locks onto the selected length, counts
// consecutive matches and raises a one-cycle pulse with the group when the count is reached.
// Assumes best is the largest matching length for the identifier offered this cycle.
module rtd_counter #(
    parameter int ID_W  = 8,
    parameter int KMAX  = 4,
    parameter int REPS  = 3,
    parameter int LEN_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      push,
    input  logic [LEN_W-1:0]          best,
    input  logic [KMAX-1:0][ID_W-1:0] window,
    output logic                      vec_pulse,
    output logic [LEN_W-1:0]          vec_len,
    output logic [KMAX*ID_W-1:0]      vec_ids
);
    localparam int MAX_NEED = rtd_pkg::fire_count(KMAX, REPS);
    localparam int RUN_W    = $clog2(MAX_NEED + 1);

    logic [LEN_W-1:0]     lock_q;
    logic [RUN_W-1:0]     run_q, run_nx, need;
    logic                 fire;
    logic [KMAX*ID_W-1:0] ids_nx;

    // Next count and firing decision for the identifier offered this cycle.
    always_comb begin
        if (best == '0)        run_nx = '0;
        else if (best != lock_q) run_nx = RUN_W'(1);
        else                   run_nx = run_q + 1'b1;
        need = RUN_W'(rtd_pkg::fire_count(int'(best), REPS));
        fire = (best != '0) && (run_nx == need);
    end

    // Group identifiers for the event: slots below the length, zero above.
    always_comb begin
        for (int j = 0; j < KMAX; j++) begin
            ids_nx[j*ID_W +: ID_W] = (j < int'(best)) ? window[j] : '0;
        end
    end

    // State and output register: reset/flush clear, push updates, idle holds count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            lock_q    <= '0;
            run_q     <= '0;
            vec_pulse <= 1'b0;
            vec_len   <= '0;
            vec_ids   <= '0;
        end else if (push) begin
            lock_q    <= best;
            run_q     <= fire ? '0 : run_nx;
            vec_pulse <= fire;
            vec_len   <= fire ? best : '0;
            vec_ids   <= fire ? ids_nx : '0;
        end else begin
            vec_pulse <= 1'b0;
            vec_len   <= '0;
            vec_ids   <= '0;
        end
    end

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pulse |=> !vec_pulse);

    assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pulse |-> (vec_len != '0 && int'(vec_len) <= KMAX));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_pulse |-> (vec_len == '0 && vec_ids == '0));

    assert_count_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pulse |-> (run_q == '0));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!vec_pulse && run_q == '0 && lock_q == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !flush) |=> ($stable(run_q) && $stable(lock_q) && !vec_pulse));
endmodule

// File: rtl/trace_repeat_detector.sv
// Top: detects a repeating group of trace identifiers and raises a vectorize event
// once the group has been seen REPS times in a row. Assumes KMAX >= 1 and REPS >= 2.
module trace_repeat_detector #(
    parameter int ID_W = rtd_pkg::DEF_ID_W,
    parameter int KMAX = rtd_pkg::DEF_KMAX,
    parameter int REPS = rtd_pkg::DEF_REPS,
    localparam int LEN_W = $clog2(KMAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 in_valid,
    input  logic [ID_W-1:0]      in_id,
    output logic                 vec_pulse,
    output logic [LEN_W-1:0]     vec_len,
    output logic [KMAX*ID_W-1:0] vec_ids
);
    logic [2*KMAX-1:0][ID_W-1:0] cand;
    logic [2*KMAX-1:0]           cand_vld;
    logic [LEN_W-1:0]            best;
    logic                        push;

    // Flush drops any identifier offered in the same cycle.
    assign push = in_valid && !flush;

    rtd_history #(.ID_W(ID_W), .KMAX(KMAX)) u_hist (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .id_in(in_id),
        .cand(cand), .cand_vld(cand_vld)
    );

    rtd_compare #(.ID_W(ID_W), .KMAX(KMAX), .LEN_W(LEN_W)) u_cmp (
        .cand(cand), .cand_vld(cand_vld), .best(best)
    );

    rtd_counter #(.ID_W(ID_W), .KMAX(KMAX), .REPS(REPS), .LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .best(best),
        .window(cand[KMAX-1:0]),
        .vec_pulse(vec_pulse), .vec_len(vec_len), .vec_ids(vec_ids)
    );
endmodule

// File: tb/sim_trace_repeat_detector.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (queue of identifiers, integer counters)
// compared against the detector on every clock.
module sim_trace_repeat_detector;
    localparam int ID_W = 8;
    localparam int KMAX = 4;
    localparam int REPS = 3;
    localparam int LEN_W = $clog2(KMAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic in_valid = 1'b0;
    logic [ID_W-1:0] in_id = '0;
    logic vec_pulse;
    logic [LEN_W-1:0] vec_len;
    logic [KMAX*ID_W-1:0] vec_ids;

    always #2 clk = ~clk;

    trace_repeat_detector #(.ID_W(ID_W), .KMAX(KMAX), .REPS(REPS)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_id(in_id),
        .vec_pulse(vec_pulse), .vec_len(vec_len), .vec_ids(vec_ids)
    );

    int checks = 0;
    int fails = 0;
    int pulses_seen = 0;
    bit done = 0;

    // Reference model state
    logic [ID_W-1:0] q[$];
    int m_lock = 0;
    int m_run = 0;
    bit e_pulse = 0;
    int e_len = 0;
    logic [KMAX*ID_W-1:0] e_ids = '0;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Model update for one clock edge, written from the requirements.
    task automatic model(input bit r, input bit f, input bit v, input logic [ID_W-1:0] id);
        int best;
        bit ok;
        e_pulse = 0; e_len = 0; e_ids = '0;
        if (!r || f) begin
            q.delete(); m_lock = 0; m_run = 0;
        end else if (v) begin
            q.push_front(id);
            if (q.size() > 2 * KMAX) void'(q.pop_back());
            best = 0;
            for (int k = 1; k <= KMAX; k++) begin
                if (q.size() >= 2 * k) begin
                    ok = 1;
                    for (int i = 0; i < k; i++) if (q[i] != q[i+k]) ok = 0;
                    if (ok) best = k;
                end
            end
            if (best == 0) begin m_run = 0; m_lock = 0; end
            else if (best != m_lock) begin m_lock = best; m_run = 1; end
            else m_run++;
            if (best != 0 && m_run == (REPS - 2) * best + 1) begin
                e_pulse = 1; e_len = best;
                for (int j = 0; j < best; j++) e_ids[j*ID_W +: ID_W] = q[j];
                m_run = 0;
            end
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at the next negedge.
    task automatic step(input bit v, input logic [ID_W-1:0] id, input bit f, input string tag);
        in_valid = v; in_id = id; flush = f;
        @(posedge clk);
        model(rst_n, f, v, id);
        @(negedge clk);
        check(tag, "pulse", vec_pulse, e_pulse);
        check("R3", "len", vec_len, e_len);
        check("R7", "ids", vec_ids, e_ids);
        if (vec_pulse) pulses_seen++;
    endtask

    task automatic feed(input logic [ID_W-1:0] id, input string tag);
        step(1'b1, id, 1'b0, tag);
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 8'h55, 1'b0, "R1");
        step(1'b1, 8'h55, 1'b0, "R1");
        check("R1", "reset pulse", vec_pulse, 0);
        check("R1", "reset len", vec_len, 0);
        check("R1", "reset ids", vec_ids, 0);
        rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b0, "R1");
        check("R1", "idle after reset", vec_pulse, 0);

        // R4: A,A,A fires length 1 on the third A
        feed(8'h11, "R2"); feed(8'h11, "R4");
        check("R4", "no pulse after two", vec_pulse, 0);
        feed(8'h11, "R4");
        check("R4", "A,A,A pulse", vec_pulse, 1);
        check("R7", "A,A,A len", vec_len, 1);
        check("R7", "A,A,A id", vec_ids, 64'h11);
        step(1'b0, 8'h00, 1'b0, "R7");
        check("R7", "pulse one cycle", vec_pulse, 0);

        // R8: flush, and an identifier offered with flush is dropped
        step(1'b1, 8'h11, 1'b1, "R8");
        feed(8'h11, "R2");
        check("R2", "first after flush no match", vec_pulse, 0);
        feed(8'h11, "R8");
        check("R8", "dropped id not counted", vec_pulse, 0);
        feed(8'h11, "R8");
        check("R8", "fires after two more", vec_pulse, 1);

        // R3/R4: A X B repeated, fires length 3 on the ninth identifier
        step(1'b0, 8'h00, 1'b1, "R8");
        for (int r = 0; r < 3; r++) begin
            feed(8'hA0, "R4"); feed(8'hB1, "R4"); feed(8'hC2, "R4");
        end
        check("R4", "AXB x3 pulse", vec_pulse, 1);
        check("R3", "AXB len", vec_len, 3);
        check("R7", "AXB ids", vec_ids, 64'h00A0B1C2);
        // R6: continuing loop fires again after 4 more
        for (int r = 0; r < 4; r++) feed(8'hA0 + 8'(((r % 3) * 8'h11)), "R6");

        // R5: period-4 loop A B B B: inner run fires length 1 first, then length 4 wins
        step(1'b0, 8'h00, 1'b1, "R8");
        for (int r = 0; r < 4; r++) begin
            feed(8'h0A, "R5"); feed(8'h0B, "R5"); feed(8'h0B, "R5"); feed(8'h0B, "R5");
        end

        // R9: idle cycles inside a loop leave the count unchanged
        step(1'b0, 8'h00, 1'b1, "R8");
        feed(8'h33, "R9");
        step(1'b0, 8'h77, 1'b0, "R9");
        step(1'b0, 8'h77, 1'b0, "R9");
        feed(8'h33, "R9");
        step(1'b0, 8'h77, 1'b0, "R9");
        check("R9", "idle no pulse", vec_pulse, 0);
        feed(8'h33, "R9");
        check("R9", "fires across idle gaps", vec_pulse, 1);

        // R5: length change restarts the count: C D C D then D D
        step(1'b0, 8'h00, 1'b1, "R8");
        feed(8'h0C, "R5"); feed(8'h0D, "R5"); feed(8'h0C, "R5"); feed(8'h0D, "R5");
        feed(8'h0D, "R5"); feed(8'h0D, "R5");
        check("R5", "restart on new length", vec_pulse, 1);

        // Mixed stream: periods 2, 3 and 4 in turn, with flushes and gaps
        for (int n = 0; n < 300; n++) begin
            int per;
            per = 2 + ((n / 40) % 3);
            if (n % 97 == 96) step(1'b0, 8'h00, 1'b1, "R8");
            else if (n % 13 == 5) step(1'b0, 8'hFF, 1'b0, "R9");
            else feed(8'(8'h40 + (n % per)), "R4");
        end
        check("R6", "several events in mixed stream", (pulses_seen > 10) ? 1 : 0, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule